// File: doc/BRIEF.md
# Auto-Reload Baud Rate Generator

This block makes the bit-rate tick for a serial port. An 8-bit up-counter advances on a selectable time base. That base is either every peripheral clock or one clock in six. When the counter passes its all-ones value it overflows and reloads from a programmable reload register. The overflows then go through an optional halving stage to become a one-cycle `baudTick` pulse. Setting a doubling bit bypasses the halving stage, so the tick rate doubles.

Software drives the generator through a small register bus. A control register holds the run, fast-clock and double-rate bits, and a second register holds the reload value. Both read back on the same bus. The tick period in peripheral clocks is (256 − reload) × (1 or 6) × (2, or 1 when doubled). A new reload value waits for the next overflow, so a running period is never cut short.

Top module: `brg_autoreload`

## Requirements
- R1: After an active-low reset the tick output is 0 and both registers read back as 0.
- R2: Address 0 is the control register: bit 0 enables the generator, bit 1 selects the fast time base, bit 2 selects double rate, and bits 7:3 read as 0. Address 1 holds the 8-bit reload value. Reads are combinational and show the value written by the previous write. Addresses 2 and 3 read 0, and writes to them change nothing.
- R3: On each time-base step the counter increments. A step taken while the count is 0xFF is an overflow, and on that step the counter loads the reload value. Overflows are therefore (256 − reload) steps apart.
- R4: With the fast bit set, the counter steps on every clock. With it clear, the counter steps once every 6 clocks. The divide-by-six phase restarts from zero whenever the generator is disabled, so the first slow step comes 6 clocks after enabling.
- R5: While the enable bit is clear, the counter holds its value and no tick is produced.
- R6: With double rate clear, a tick follows every second overflow. After reset the first overflow gives no tick, so the tick period is 2 × (256 − reload) steps.
- R7: With double rate set, every overflow gives a tick, so the period is (256 − reload) steps.
- R8: Writing the reload register does not change the running count. The new value is used at the next overflow, and an overflow in the same cycle as the write still loads the old value.
- R9: The tick is a registered pulse. It goes high for exactly one clock, in the cycle after the clock edge on which the overflow happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data for busAddr |
| baudTick | output | 1 | One-cycle baud-rate tick |

## Verification
Two functions can land on the same clock edge: a bus write and a counter overflow. The bench provokes this in two ways. It follows its model's count in fast mode and writes the reload register, or clears the enable bit, at the exact moment the count reaches 0xFF. The behavioural model, checked on every clock, expects the overflow on that edge to use the old reload value and the old enable. It also expects the tick that overflow produces to still appear, and no tick after it. Period measurements are taken around a reload write made mid-period, to confirm that the old period finishes and the new one follows.

// File: rtl/brg_pkg.sv
package brg_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;     // counter step this cycle
    logic bypassHalf;  // double-rate: skip the halving stage
  } brgStrobe_t;

  localparam int CTRL_ADDR   = 0;
  localparam int RELOAD_ADDR = 1;

  localparam int RUN_BIT  = 0;
  localparam int FAST_BIT = 1;
  localparam int DBL_BIT  = 2;

endpackage

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  output logic stepEn
);

  generate
    if (DIV <= 1) begin : g_direct
      assign stepEn = ~clear;
    end else begin : g_count
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phaseCnt;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          phaseCnt <= '0;
        end else if (clear) begin
          phaseCnt <= '0;
        end else if (phaseCnt == LAST) begin
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end

      assign stepEn = !clear && (phaseCnt == LAST);

      // R4: phase stays in range and restarts after a clear
      a_r4_phase_range: assert property (@(posedge clk) disable iff (!rstN)
        phaseCnt <= LAST);
      a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rstN)
        clear |=> (phaseCnt == '0));
    end
  endgenerate

endmodule

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 6,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWData,
  output logic [CNT_W-1:0]  busRData,
  output logic [CNT_W-1:0]  reloadVal,
  output brgStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(RELOAD_ADDR);

  logic runEn, fastClk, dblRate;
  logic [CNT_W-1:0] reloadReg;
  logic wrCtrl, wrReload, preStep;

  assign wrCtrl   = busWrEn && (busAddr == A_CTRL);
  assign wrReload = busWrEn && (busAddr == A_RELOAD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      fastClk <= 1'b0;
      dblRate <= 1'b0;
    end else if (wrCtrl) begin
      runEn   <= busWData[RUN_BIT];
      fastClk <= busWData[FAST_BIT];
      dblRate <= busWData[DBL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
    end else if (wrReload) begin
      reloadReg <= busWData;
    end
  end

  always_comb begin
    busRData = '0;
    case (busAddr)
      A_CTRL: begin
        busRData[RUN_BIT]  = runEn;
        busRData[FAST_BIT] = fastClk;
        busRData[DBL_BIT]  = dblRate;
      end
      A_RELOAD: busRData = reloadReg;
      default:  busRData = '0;
    endcase
  end

  brg_prescale #(.DIV(PRESCALE)) u_prescale (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (!runEn),
    .stepEn (preStep)
  );

  assign strobe.advance    = runEn && (fastClk || preStep);
  assign strobe.bypassHalf = dblRate;
  assign reloadVal         = reloadReg;

  // R5: no counter step while disabled
  a_r5_idle_no_step: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !strobe.advance);
  // R4: slow base never steps on two adjacent clocks
  a_r4_slow_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !fastClk) |=> (!strobe.advance || fastClk));
  // R2: reload register captures write data
  a_r2_reload_write: assert property (@(posedge clk) disable iff (!rstN)
    wrReload |=> (reloadVal == $past(busWData)));

endmodule

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  brgStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             baudTick
);

  logic [CNT_W-1:0] countQ;
  logic             halfTog;
  logic             tickQ;
  logic             overflow;

  assign overflow = strobe.advance && (countQ == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.advance) begin
      countQ <= overflow ? reloadVal : countQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfTog <= 1'b0;
    end else if (overflow) begin
      halfTog <= ~halfTog;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickQ <= 1'b0;
    end else begin
      tickQ <= overflow && (strobe.bypassHalf || halfTog);
    end
  end

  assign baudTick = tickQ;

  // R3: overflow loads the reload value
  a_r3_reload_on_overflow: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> (countQ == $past(reloadVal)));
  // R5: count holds without a step
  a_r5_hold_count: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(countQ));
  // R9: every tick is caused by the overflow one edge earlier
  a_r9_tick_after_overflow: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> $past(overflow));
  // R7: doubled rate ticks on every overflow
  a_r7_every_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && strobe.bypassHalf) |=> baudTick);
  // R6: halving stage suppresses alternate overflows
  a_r6_skip_alternate: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.bypassHalf && !halfTog) |=> !baudTick);

endmodule

// File: rtl/brg_autoreload.sv
module brg_autoreload
  import brg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 6,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWData,
  output logic [CNT_W-1:0]  busRData,
  output logic              baudTick
);

  brgStrobe_t       strobe;
  logic [CNT_W-1:0] reloadVal;

  brg_ctrl #(
    .CNT_W    (CNT_W),
    .PRESCALE (PRESCALE),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWData  (busWData),
    .busRData  (busRData),
    .reloadVal (reloadVal),
    .strobe    (strobe)
  );

  brg_datapath #(
    .CNT_W (CNT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reloadVal (reloadVal),
    .baudTick  (baudTick)
  );

endmodule

// File: tb/brg_autoreload_bench.sv
`timescale 1ns/1ps
module brg_autoreload_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWData = '0;
  logic [7:0] busRData;
  logic       baudTick;

  always #5 clk = ~clk;

  brg_autoreload u_brg_autoreload (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWData(busWData), .busRData(busRData), .baudTick(baudTick)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";
  bit done = 0;

  // behavioural model state
  bit mRun, mFast, mDbl, mTick, mParity;
  int mReload, mCount, mPhase;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      mRun = 0; mFast = 0; mDbl = 0; mTick = 0; mParity = 0;
      mReload = 0; mCount = 0; mPhase = 0;
    end else begin
      bit step, wrap;
      step = mRun && (mFast || mPhase == 5);
      wrap = step && (mCount == 255);
      mTick = wrap && (mDbl || mParity);
      if (wrap) mParity = !mParity;
      if (step) mCount = wrap ? mReload : mCount + 1;
      mPhase = !mRun ? 0 : (mPhase + 1) % 6;
      if (busWrEn && busAddr == 2'd0) begin
        mRun = busWData[0]; mFast = busWData[1]; mDbl = busWData[2];
      end
      if (busWrEn && busAddr == 2'd1) mReload = busWData;
    end
  end

  function automatic int expRead(input int a);
    if (a == 0) return {mDbl, mFast, mRun};
    if (a == 1) return mReload;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, baudTick, mTick, "tick vs model");
      check(curReq, busRData, expRead(busAddr), "readback vs model");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busAddr = a[1:0]; busWData = d[7:0]; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input int a, input int exp);
    @(negedge clk);
    busAddr = a[1:0];
    #1;
    check(req, busRData, exp, "register read");
  endtask

  // wait for a tick at a negedge; returns 0 on timeout
  task automatic waitTick(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (baudTick) begin ok = 1; break; end
    end
  endtask

  task automatic measure(input string req, input int exp);
    bit ok;
    int n;
    waitTick(ok);
    if (!ok) begin check(req, 0, 1, "tick seen"); return; end
    @(negedge clk);
    check(req, baudTick, 0, "tick width one cycle");
    n = 1;
    while (!baudTick && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(req, n, exp, "tick period");
  endtask

  task automatic waitModelCount(input int v);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (mCount == v) break;
    end
  endtask

  // watchdog
  always @(negedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    int seen;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    curReq = "R1";
    check("R1", baudTick, 0, "tick after reset");
    rdChk("R1", 0, 0);
    rdChk("R1", 1, 0);

    // R2 register map
    curReq = "R2";
    wr(1, 8'hF0);
    rdChk("R2", 1, 8'hF0);
    wr(0, 8'hF8);
    rdChk("R2", 0, 8'h00);
    wr(2, 8'h55);
    wr(3, 8'hAA);
    rdChk("R2", 2, 0);
    rdChk("R2", 3, 0);
    rdChk("R2", 1, 8'hF0);

    // R7 + R3: fast, doubled, reload F0 -> 16
    curReq = "R7";
    wr(0, 8'b111);
    measure("R7", 16);
    measure("R3", 16);

    // R6: fast, not doubled -> 32
    curReq = "R6";
    wr(0, 8'b011);
    measure("R6", 32);
    measure("R9", 32);

    // R4: slow base, reload FC
    curReq = "R4";
    wr(1, 8'hFC);
    wr(0, 8'b101);
    measure("R4", 24);
    wr(0, 8'b001);
    measure("R4", 48);

    // R5: disabled, no ticks
    curReq = "R5";
    wr(0, 8'b000);
    seen = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (baudTick) seen++;
    end
    check("R5", seen, 0, "ticks while disabled");

    // R8: reload write mid-period
    curReq = "R8";
    wr(1, 8'hF0);
    wr(0, 8'b111);
    waitTick(ok);
    repeat (4) @(negedge clk);
    busAddr = 2'd1; busWData = 8'h80; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    for (int i = 0; i < 4000 && !baudTick; i++) @(negedge clk);
    measure("R8", 128);

    // R8 concurrency: write lands on the overflow edge
    wr(1, 8'hE0);
    waitModelCount(255);
    busAddr = 2'd1; busWData = 8'hF8; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R8", baudTick, 1, "tick from overflow with old reload");
    measure("R8", 8);

    // R5 concurrency: disable lands on the overflow edge
    curReq = "R5";
    waitModelCount(255);
    busAddr = 2'd0; busWData = 8'h00; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R5", baudTick, 1, "last tick on disabling edge");
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (baudTick) seen++;
    end
    check("R5", seen, 0, "no ticks after disable");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule